// File: doc/BRIEF.md
# Flash Command Status and Configuration Registers

This block is the software-visible front of a flash command engine. It holds two byte-wide registers on a small read/write port: a status register and a configuration register. Software starts a command by writing a one to the command-complete flag while it is set; the block then drops the flag and pulses a launch strobe to the engine. The engine reports completion, errors and read collisions back as single-cycle pulses. An error status bit records any engine error and cannot be cleared by software. It is discarded automatically on the clock edge after the next command is accepted.

An erase-all request can arrive from outside the block, for example from a debug or chip-configuration path. It is accepted only when no command is running. In that case it arms a read-only request bit, starts the engine through a separate strobe, and the request bit stays set until the engine reports completion. A trigger that arrives while the engine is busy is dropped. One interrupt line is driven from a clocked OR of the enabled events.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no back-pressure: every write is taken in the cycle it is presented. The engine pulses are also accepted unconditionally.

Top module: `fcr_regs`

## Requirements
- R1: After reset the status register reads 0x80 (command-complete flag set, collision flag and error bit clear), the configuration register reads 0x00, and `irq`, `cmd_launch` and `erase_all_go` are 0.
- R2: Configuration register (address 1): bit 7 is the command-complete interrupt enable and bit 6 is the read-collision interrupt enable. Both are read/write. Bits 4..0 always read 0 and ignore writes.
- R3: Configuration bit 5 is the erase-all request. A software write never changes it. It reads 1 from the cycle after an accepted external trigger until the cycle after the engine's done pulse.
- R4: Status register (address 0) bit 7 is the command-complete flag. A write with bit 7 = 1 while the flag is 1 clears the flag and produces a one-cycle `cmd_launch` pulse in the following cycle. The same write while the flag is 0 has no effect.
- R5: An `eng_done` pulse sets the command-complete flag on the next edge. A launch accepted in the same cycle takes priority.
- R6: `ext_erase_trig` while the command-complete flag is 1 and no software launch is accepted in that cycle does three things: it clears the flag, sets the erase-all request bit, and produces a one-cycle `erase_all_go` pulse in the following cycle. Otherwise the trigger is ignored and not remembered.
- R7: Status bit 0 is the error status. It is set by `eng_err` at any time, including while idle, and software writes never clear it. It clears on the edge after a launch or erase-all start is accepted, that is, on the edge that ends the `cmd_launch` or `erase_all_go` pulse. An `eng_err` in that cycle sets it instead.
- R8: Status bit 6 is the read-collision flag. It is set by `eng_rd_col` and cleared by a status write with bit 6 = 1. A set in the same cycle as the clear wins.
- R9: Status bits 5..1 always read 0.
- R10: `irq` is registered. In each cycle it equals the previous cycle's value of (CC enable AND command-complete flag) OR (collision enable AND collision flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 1 | Register select: 0 status, 1 configuration |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_erase_trig | input | 1 | External erase-all trigger pulse |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse (command or reset sequence) |
| eng_rd_col | input | 1 | Engine read-collision pulse |
| cmd_launch | output | 1 | One-cycle strobe starting a software command |
| erase_all_go | output | 1 | One-cycle strobe starting erase-all |
| erase_all_busy | output | 1 | Level copy of the erase-all request bit |
| irq | output | 1 | Registered interrupt request |

## Verification
Directed sequences first cover the idle-only arming rules. A launch write or trigger is issued while busy, which separates a block that drops the request from one that queues it. A launch and a trigger in the same cycle show the priority. An error pulse in the clear cycle distinguishes set-wins from clear-wins. A long run of random writes and engine pulses then mixes address, write data, trigger timing and error timing against a cycle model. That run separates correct write masking and write-one-to-clear behaviour from plain read/write storage, and it checks that the one-cycle interrupt latency holds for every combination of enables and flags.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int unsigned REG_W     = 8;
  localparam logic        ADR_STAT  = 1'b0;
  localparam logic        ADR_CNFG  = 1'b1;
  // status bit positions
  localparam int unsigned ST_CC     = 7;
  localparam int unsigned ST_COL    = 6;
  localparam int unsigned ST_ERR    = 0;
  // configuration bit positions
  localparam int unsigned CF_CCIE   = 7;
  localparam int unsigned CF_COLIE  = 6;
  localparam int unsigned CF_ERSREQ = 5;
  // interrupt sources
  localparam int unsigned N_IRQ_SRC = 2;
endpackage

// File: rtl/fcr_cnfg_reg.sv
module fcr_cnfg_reg
  import fcr_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         cc_ie,
  output logic         col_ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_ie  <= 1'b0;
      col_ie <= 1'b0;
    end else if (wr_en) begin
      cc_ie  <= wdata[CF_CCIE];
      col_ie <= wdata[CF_COLIE];
    end
  end
endmodule

// File: rtl/fcr_cmd_seq.sv
module fcr_cmd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_go_req,
  input  logic ext_trig,
  input  logic eng_done,
  input  logic eng_err,
  output logic cc_flag,
  output logic ers_req,
  output logic launch_q,
  output logic ers_go_q,
  output logic err_stat
);
  logic acc_sw, acc_ext;

  assign acc_sw  = sw_go_req & cc_flag;
  assign acc_ext = ext_trig & cc_flag & ~acc_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_flag  <= 1'b1;
      ers_req  <= 1'b0;
      launch_q <= 1'b0;
      ers_go_q <= 1'b0;
      err_stat <= 1'b0;
    end else begin
      launch_q <= acc_sw;
      ers_go_q <= acc_ext;
      if (acc_sw || acc_ext)  cc_flag <= 1'b0;
      else if (eng_done)      cc_flag <= 1'b1;
      if (acc_ext)            ers_req <= 1'b1;
      else if (eng_done)      ers_req <= 1'b0;
      if (eng_err)                     err_stat <= 1'b1;
      else if (launch_q || ers_go_q)   err_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/fcr_col_flag.sv
module fcr_col_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set_i)  flag <= 1'b1;
    else if (clr_i)  flag <= 1'b0;
  end
endmodule

// File: rtl/fcr_irq_gen.sv
module fcr_irq_gen #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] enable,
  input  logic [NSRC-1:0] event_lvl,
  output logic            irq
);
  logic [NSRC-1:0] term;

  for (genvar g = 0; g < NSRC; g++) begin : g_term
    assign term[g] = enable[g] & event_lvl[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |term;
  end
endmodule

// File: rtl/fcr_regs.sv
module fcr_regs
  import fcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ext_erase_trig,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             eng_rd_col,
  output logic             cmd_launch,
  output logic             erase_all_go,
  output logic             erase_all_busy,
  output logic             irq
);
  logic wr_stat, wr_cnfg;
  logic cc_ie, col_ie;
  logic cc_flag, ers_req, err_stat, col_flag;
  logic [REG_W-1:0] stat_view, cnfg_view;

  assign wr_stat = reg_wr & (reg_addr == ADR_STAT);
  assign wr_cnfg = reg_wr & (reg_addr == ADR_CNFG);

  fcr_cnfg_reg #(.W(REG_W)) u_cnfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cnfg), .wdata(reg_wdata),
    .cc_ie(cc_ie), .col_ie(col_ie)
  );

  fcr_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .sw_go_req(wr_stat & reg_wdata[ST_CC]),
    .ext_trig(ext_erase_trig), .eng_done(eng_done), .eng_err(eng_err),
    .cc_flag(cc_flag), .ers_req(ers_req),
    .launch_q(cmd_launch), .ers_go_q(erase_all_go), .err_stat(err_stat)
  );

  fcr_col_flag u_col (
    .clk(clk), .rst_n(rst_n), .set_i(eng_rd_col),
    .clr_i(wr_stat & reg_wdata[ST_COL]), .flag(col_flag)
  );

  fcr_irq_gen #(.NSRC(N_IRQ_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .enable({col_ie, cc_ie}), .event_lvl({col_flag, cc_flag}),
    .irq(irq)
  );

  always_comb begin
    stat_view          = '0;
    stat_view[ST_CC]   = cc_flag;
    stat_view[ST_COL]  = col_flag;
    stat_view[ST_ERR]  = err_stat;
    cnfg_view            = '0;
    cnfg_view[CF_CCIE]   = cc_ie;
    cnfg_view[CF_COLIE]  = col_ie;
    cnfg_view[CF_ERSREQ] = ers_req;
  end

  assign reg_rdata      = (reg_addr == ADR_CNFG) ? cnfg_view : stat_view;
  assign erase_all_busy = ers_req;
endmodule

// File: rtl/fcr_regs_chk.sv
module fcr_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic       ext_erase_trig,
  input logic       eng_done,
  input logic       eng_err,
  input logic       cmd_launch,
  input logic       erase_all_go,
  input logic       erase_all_busy,
  input logic       irq,
  input logic       cc_flag,
  input logic       col_flag,
  input logic       cc_ie,
  input logic       col_ie,
  input logic       err_stat
);
  AST_LAUNCH_DROPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |-> !cc_flag); // R4
  AST_BUSY_WRITE_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_flag && reg_wr && !reg_addr && reg_wdata[7]) |=> !cmd_launch); // R4
  AST_DONE_SETS_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !(reg_wr && !reg_addr && reg_wdata[7]) && !ext_erase_trig) |=> cc_flag); // R5
  AST_TRIG_IDLE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_erase_trig && cc_flag && !(reg_wr && !reg_addr && reg_wdata[7])) |=> (erase_all_go && erase_all_busy && !cc_flag)); // R6
  AST_TRIG_BUSY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_erase_trig && !cc_flag) |=> !erase_all_go); // R6
  AST_CFG_WRITE_NO_ERS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && !ext_erase_trig && !eng_done) |=> $stable(erase_all_busy)); // R3
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_stat); // R7
  AST_ERR_CLEARS_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_launch || erase_all_go) && !eng_err) |=> !err_stat); // R7
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past((cc_ie && cc_flag) || (col_ie && col_flag))); // R10
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_launch, erase_all_go})); // R6
endmodule

bind fcr_regs fcr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ext_erase_trig(ext_erase_trig),
  .eng_done(eng_done), .eng_err(eng_err), .cmd_launch(cmd_launch),
  .erase_all_go(erase_all_go), .erase_all_busy(erase_all_busy), .irq(irq),
  .cc_flag(cc_flag), .col_flag(col_flag), .cc_ie(cc_ie), .col_ie(col_ie),
  .err_stat(err_stat)
);

// File: tb/test_fcr_regs.sv
`timescale 1ns/1ps
module test_fcr_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_erase_trig = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_rd_col = 1'b0;
  logic       cmd_launch, erase_all_go, erase_all_busy, irq;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  // reference state
  logic m_cc = 1, m_col = 0, m_err = 0, m_ccie = 0, m_colie = 0, m_ers = 0;
  logic m_launch = 0, m_go = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  fcr_regs i_fcr_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_erase_trig(ext_erase_trig),
    .eng_done(eng_done), .eng_err(eng_err), .eng_rd_col(eng_rd_col),
    .cmd_launch(cmd_launch), .erase_all_go(erase_all_go),
    .erase_all_busy(erase_all_busy), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {m_cc, m_col, 5'b0, m_err};
  endfunction

  function automatic logic [7:0] exp_cnfg();
    return {m_ccie, m_colie, m_ers, 5'b0};
  endfunction

  task automatic model_tick(input logic wr, input logic ad, input logic [7:0] wd,
                            input logic ext, input logic dn, input logic er, input logic cl);
    logic acc_sw, acc_ext;
    logic n_cc, n_ers, n_err, n_col, n_irq;
    acc_sw  = wr && !ad && wd[7] && m_cc;
    acc_ext = ext && m_cc && !acc_sw;
    n_irq = (m_ccie && m_cc) || (m_colie && m_col);
    n_cc  = (acc_sw || acc_ext) ? 1'b0 : (dn ? 1'b1 : m_cc);
    n_ers = acc_ext ? 1'b1 : (dn ? 1'b0 : m_ers);
    n_err = er ? 1'b1 : ((m_launch || m_go) ? 1'b0 : m_err);
    n_col = cl ? 1'b1 : ((wr && !ad && wd[6]) ? 1'b0 : m_col);
    if (wr && ad) begin
      m_ccie  = wd[7];
      m_colie = wd[6];
    end
    m_cc = n_cc; m_ers = n_ers; m_err = n_err; m_col = n_col; m_irq = n_irq;
    m_launch = acc_sw; m_go = acc_ext;
  endtask

  // one cycle: compare registered outputs, drive, compare read data, clock model
  task automatic step(input logic wr, input logic ad, input logic [7:0] wd,
                      input logic ext, input logic dn, input logic er, input logic cl);
    @(negedge clk);
    check("R4 cmd_launch", {7'b0, cmd_launch}, {7'b0, m_launch});
    check("R6 erase_all_go", {7'b0, erase_all_go}, {7'b0, m_go});
    check("R3 erase_all_busy", {7'b0, erase_all_busy}, {7'b0, m_ers});
    check("R10 irq", {7'b0, irq}, {7'b0, m_irq});
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    ext_erase_trig = ext; eng_done = dn; eng_err = er; eng_rd_col = cl;
    #1;
    if (ad) check("R2 R3 config read", reg_rdata, exp_cnfg());
    else    check("R4 R5 R7 R8 R9 status read", reg_rdata, exp_stat());
    @(posedge clk);
    model_tick(wr, ad, wd, ext, dn, er, cl);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    reg_addr = 1'b0; #1 check("R1 status reset", reg_rdata, 8'h80);
    reg_addr = 1'b1; #1 check("R1 config reset", reg_rdata, 8'h00);
    check("R1 irq reset", {7'b0, irq}, 8'h00);
    check("R1 launch reset", {6'b0, cmd_launch, erase_all_go}, 8'h00);
    rst_n = 1'b1;
    // R2 R3: write all ones to config, read back 0xC0
    step(1, 1, 8'hFF, 0, 0, 0, 0);
    step(0, 1, 8'h00, 0, 0, 0, 0);
    check("R2 config masked", reg_rdata, 8'hC0);
    // reset-sequence style error while idle (R7)
    step(0, 0, 8'h00, 0, 0, 1, 0);
    step(1, 0, 8'h01, 0, 0, 0, 0);   // software write cannot clear R7
    step(0, 0, 8'h00, 0, 0, 0, 0);
    check("R7 err held", reg_rdata, 8'h80 | 8'h01);
    // R4 launch; R7 clear one cycle later
    step(1, 0, 8'h80, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 0);
    check("R7 err cleared after launch", reg_rdata, 8'h00);
    // busy: launch write and trigger ignored (R4, R6)
    step(1, 0, 8'h80, 1, 0, 0, 0);
    step(0, 1, 8'h00, 0, 1, 0, 0);   // done (R5)
    step(0, 0, 8'h00, 0, 0, 0, 0);
    check("R6 busy trigger not queued", {7'b0, erase_all_busy}, 8'h00);
    // R6 trigger while idle, then done clears request (R3)
    step(0, 1, 8'h00, 1, 0, 0, 0);
    step(1, 1, 8'hDF, 0, 0, 0, 0);
    step(0, 1, 8'h00, 0, 1, 0, 0);
    step(0, 1, 8'h00, 0, 0, 0, 0);
    // same-cycle launch and trigger: launch wins (R6)
    step(1, 0, 8'h80, 1, 0, 1, 0);
    step(0, 0, 8'h00, 0, 0, 1, 0);   // error in clear cycle wins (R7)
    step(0, 0, 8'h00, 0, 1, 0, 0);
    // R8 collision set beats clear
    step(1, 0, 8'h40, 0, 0, 0, 1);
    step(1, 0, 8'h40, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd;
      wd = 8'($urandom);
      step(($urandom % 3) == 0, 1'($urandom), wd,
           ($urandom % 7) == 0, ($urandom % 5) == 0,
           ($urandom % 9) == 0, ($urandom % 8) == 0);
    end
    step(0, 0, 8'h00, 0, 0, 0, 0);
    done_flag = 1;
    finish_run();
  end
endmodule